// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block decides where each memory access below the 1 MB boundary is sent, and whether an access falls inside a programmable system-management RAM window. A small bank of byte-wide control registers is loaded through a strobed write port and read back through an index-addressed read port. For every incoming physical address and access direction, the block drives a purely combinational routing decision. The decision is one of three: serve from local DRAM, forward to the external bus, or claim as a system-management RAM hit.

The legacy area is split into attribute segments. Two larger ones cover 512 KB to 640 KB and the top 64 KB below 1 MB. Twelve 16 KB segments cover the option-ROM area. Each segment has its own read-enable bit and its own write-enable bit, so a region can be read from DRAM while writes still go to the external bus. The 128 KB video window has a single on/off control. The management window has a base, a size and an enable, and it overrides every other decision.

Top module: `legacy_region_decoder`

## Requirements
- R1: After a synchronous active-low reset, these registers read back as follows: index 0x59 reads 0x03, indices 0x5A to 0x5F read 0x00, index 0xB8 reads 0x0A, and indices 0x57, 0x58, 0xB9 and 0xBB read 0x00.
- R2: A write stores only the implemented bits, and a read returns them. The implemented bits are: mask 0x33 for 0x59 to 0x5F, mask 0x08 for 0x57, mask 0x02 for 0x58, mask 0xF0 for 0xBB, and all bits for 0xB8 and 0xB9. A write is sampled on the rising clock edge where the strobe is high, and the routing outputs reflect it only after that edge.
- R3: A write to any other index changes no state, and a read of any other index returns 0x00.
- R4: The low nibble of index 0x59 controls 0x80000 to 0x9FFFF. Its high nibble controls 0xF0000 to 0xFFFFF.
- R5: Index 0x5A+n (n = 0..5) controls two segments with its low nibble and high nibble respectively. The low nibble controls the 16 KB segment at 0xC0000 + n*0x8000. The high nibble controls the 16 KB segment at 0xC4000 + n*0x8000.
- R6: In each nibble, bit 0 set sends reads to local DRAM, and bit 1 set sends writes to local DRAM. A clear bit sends that access type to the external bus.
- R7: Bit 1 of index 0x58 set sends both reads and writes in 0xA0000 to 0xBFFFF to local DRAM. When the bit is clear, the window goes to the external bus.
- R8: The management window starts at {idx 0xB9, idx 0xB8} shifted left by 16. It spans (idx 0xBB bits 7:4 + 1) x 64 KB.
- R9: The management window is active only when bit 3 of index 0x57 is set and the 16-bit base value is nonzero.
- R10: An address in an active management window is routed as a management hit. This holds for reads and writes alike, and wins over the video and attribute-segment decisions.
- R11: Addresses outside every decoded region go to local DRAM.
- R12: Exactly one of the three routing outputs is high at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 8 | Register index for a write |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_idx | input | 8 | Register index for a read |
| cfg_rd_data | output | 8 | Masked stored value, or 0x00 for an unused index |
| req_addr | input | ADDR_W | Physical address under decode |
| req_is_write | input | 1 | 1 for a write access, 0 for a read |
| route_local | output | 1 | Access goes to local DRAM |
| route_ext | output | 1 | Access goes to the external bus |
| route_smm | output | 1 | Access hits the management RAM window |

## Verification
The bench looks for off-by-one segment edges by probing the first and last byte of every segment with all four attribute codes. A design that mixed up the segment order or the nibbles would send the wrong access direction to DRAM. A register write is checked both before and after its clock edge; a design that forwarded write data combinationally would change the route one cycle early. The management window is tested in four ways: using the reset base, with a zero base while enabled, at the top of the 32-bit space where the end address overflows, and with the enable cleared. A design that skipped the zero-base rule would claim the bottom of memory. A design that truncated the end address would miss the highest window.

// File: rtl/lrd_pkg.sv
// Package: shared constants and helpers for the legacy region decoder.
// Assumes a 16 KB granule for option-ROM segments and 64 KB units for the
// management window size field.
package lrd_pkg;

    // Register indices; the bench and software address the block by these.
    localparam logic [7:0] IDX_SMM_CTL  = 8'h57;
    localparam logic [7:0] IDX_VID_CTL  = 8'h58;
    localparam logic [7:0] IDX_SHADOW0  = 8'h59;
    localparam logic [7:0] IDX_SMM_LO   = 8'hB8;
    localparam logic [7:0] IDX_SMM_HI   = 8'hB9;
    localparam logic [7:0] IDX_SMM_SZ   = 8'hBB;

    // Implemented-bit masks.
    localparam logic [7:0] MSK_SMM_CTL  = 8'h08;
    localparam logic [7:0] MSK_VID_CTL  = 8'h02;
    localparam logic [7:0] MSK_SHADOW   = 8'h33;
    localparam logic [7:0] MSK_SMM_SZ   = 8'hF0;

    // Reset values.
    localparam logic [7:0] RST_SHADOW0  = 8'h03;
    localparam logic [7:0] RST_SMM_LO   = 8'h0A;

    // Fixed legacy map.
    localparam int unsigned LOW_SEG_BASE  = 32'h0008_0000;
    localparam int unsigned LOW_SEG_SIZE  = 32'h0002_0000;
    localparam int unsigned TOP_SEG_BASE  = 32'h000F_0000;
    localparam int unsigned TOP_SEG_SIZE  = 32'h0001_0000;
    localparam int unsigned ROM_SEG_BASE  = 32'h000C_0000;
    localparam int unsigned ROM_SEG_SIZE  = 32'h0000_4000;
    localparam int unsigned VID_BASE      = 32'h000A_0000;
    localparam int unsigned VID_SIZE      = 32'h0002_0000;

    // Base of attribute segment s: s=0 low area, s=1 top area, s>=2 ROM granules.
    function automatic int unsigned seg_base(input int s);
        if (s == 0)      return LOW_SEG_BASE;
        else if (s == 1) return TOP_SEG_BASE;
        else             return ROM_SEG_BASE + ROM_SEG_SIZE * (s - 2);
    endfunction

    // Size of attribute segment s.
    function automatic int unsigned seg_size(input int s);
        if (s == 0)      return LOW_SEG_SIZE;
        else if (s == 1) return TOP_SEG_SIZE;
        else             return ROM_SEG_SIZE;
    endfunction

    // True when idx names an implemented register.
    function automatic logic idx_known(input logic [7:0] idx, input int nshadow);
        logic hit;
        hit = (idx == IDX_SMM_CTL) || (idx == IDX_VID_CTL) || (idx == IDX_SMM_LO) ||
              (idx == IDX_SMM_HI) || (idx == IDX_SMM_SZ);
        for (int i = 0; i < nshadow; i++)
            if (idx == 8'(IDX_SHADOW0 + 8'(i))) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/lrd_cfg_regs.sv
// Module: configuration register bank.
// Stores masked register bytes, provides combinational readback and hands
// decoded control fields to the address decoders. Assumes writes are
// single-cycle strobes sampled on the rising clock edge.
module lrd_cfg_regs
    import lrd_pkg::*;
#(
    parameter int NUM_SHADOW = 7,
    localparam int NUM_SEG   = 2 * NUM_SHADOW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_idx,
    input  logic [7:0]                wr_data,
    input  logic [7:0]                rd_idx,
    output logic [7:0]                rd_data,
    output logic [NUM_SEG-1:0][1:0]   seg_attr,
    output logic                      vid_local,
    output logic                      smm_en,
    output logic [15:0]               smm_base16,
    output logic [3:0]                smm_size_m1
);

    logic [7:0] smm_ctl_q, vid_ctl_q, smm_lo_q, smm_hi_q, smm_sz_q;
    logic [NUM_SHADOW-1:0][7:0] shadow_q;

    // Scalar control registers: masked store on a matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smm_ctl_q <= 8'h00;
            vid_ctl_q <= 8'h00;
            smm_lo_q  <= RST_SMM_LO;
            smm_hi_q  <= 8'h00;
            smm_sz_q  <= 8'h00;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_SMM_CTL: smm_ctl_q <= wr_data & MSK_SMM_CTL;
                IDX_VID_CTL: vid_ctl_q <= wr_data & MSK_VID_CTL;
                IDX_SMM_LO:  smm_lo_q  <= wr_data;
                IDX_SMM_HI:  smm_hi_q  <= wr_data;
                IDX_SMM_SZ:  smm_sz_q  <= wr_data & MSK_SMM_SZ;
                default: ;
            endcase
        end
    end

    // One attribute register per shadow byte, each with its own index.
    for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_shadow
        localparam logic [7:0] MY_IDX = 8'(IDX_SHADOW0 + 8'(g));
        localparam logic [7:0] MY_RST = (g == 0) ? RST_SHADOW0 : 8'h00;

        // Masked store of this attribute byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[g] <= MY_RST;
            else if (wr_en && wr_idx == MY_IDX)
                shadow_q[g] <= wr_data & MSK_SHADOW;
        end

        assign seg_attr[2*g]     = shadow_q[g][1:0];
        assign seg_attr[2*g + 1] = shadow_q[g][5:4];
    end

    // Readback multiplexer; unused indices return zero.
    always_comb begin
        rd_data = 8'h00;
        case (rd_idx)
            IDX_SMM_CTL: rd_data = smm_ctl_q;
            IDX_VID_CTL: rd_data = vid_ctl_q;
            IDX_SMM_LO:  rd_data = smm_lo_q;
            IDX_SMM_HI:  rd_data = smm_hi_q;
            IDX_SMM_SZ:  rd_data = smm_sz_q;
            default: ;
        endcase
        for (int i = 0; i < NUM_SHADOW; i++)
            if (rd_idx == 8'(IDX_SHADOW0 + 8'(i))) rd_data = shadow_q[i];
    end

    assign vid_local   = vid_ctl_q[1];
    assign smm_en      = smm_ctl_q[3];
    assign smm_base16  = {smm_hi_q, smm_lo_q};
    assign smm_size_m1 = smm_sz_q[7:4];

    // R3: a write to an unused index leaves every stored byte untouched.
    assert_unused_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idx_known(wr_idx, NUM_SHADOW)) |=>
            $stable({smm_ctl_q, vid_ctl_q, smm_lo_q, smm_hi_q, smm_sz_q, shadow_q}));

    // R2: state changes only through a write strobe.
    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({smm_ctl_q, vid_ctl_q, smm_lo_q, smm_hi_q, smm_sz_q, shadow_q}));

endmodule

// File: rtl/lrd_legacy_decode.sv
// Module: legacy-area decoder.
// Matches the address against the video window and every attribute
// segment, then picks the DRAM/external choice for the access direction.
// Assumes segments do not overlap each other or the video window.
module lrd_legacy_decode
    import lrd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_SEG = 14
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     is_write,
    input  logic [NUM_SEG-1:0][1:0]  seg_attr,
    input  logic                     vid_local,
    output logic                     vid_hit,
    output logic                     seg_hit,
    output logic                     want_local
);

    localparam int AW1 = ADDR_W + 1;

    logic [AW1-1:0]     addr_x;
    logic [NUM_SEG-1:0] hit_vec;
    logic [NUM_SEG-1:0] dram_vec;

    assign addr_x = {1'b0, addr};

    // Per-segment range match and direction-specific enable.
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam logic [AW1-1:0] LO = AW1'(seg_base(s));
        localparam logic [AW1-1:0] HI = AW1'(seg_base(s) + seg_size(s));
        assign hit_vec[s]  = (addr_x >= LO) && (addr_x < HI);
        assign dram_vec[s] = is_write ? seg_attr[s][1] : seg_attr[s][0];
    end

    localparam logic [AW1-1:0] VLO = AW1'(VID_BASE);
    localparam logic [AW1-1:0] VHI = AW1'(VID_BASE + VID_SIZE);

    // Video window match.
    assign vid_hit = (addr_x >= VLO) && (addr_x < VHI);

    // Combine: video control wins inside its window, else the matching segment.
    always_comb begin
        seg_hit    = |hit_vec;
        want_local = 1'b1;
        if (vid_hit)
            want_local = vid_local;
        else if (seg_hit)
            want_local = |(hit_vec & dram_vec);
    end

endmodule

// File: rtl/lrd_smm_window.sv
// Module: management RAM window comparator.
// Builds base and end from the 16-bit base field and the size nibble, and
// flags a hit. Assumes ADDR_W >= 32; the end address is kept one bit wider
// so a window touching the top of the space does not wrap.
module lrd_smm_window #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              enable,
    input  logic [15:0]       base16,
    input  logic [3:0]        size_m1,
    output logic              hit
);

    localparam int AW1 = ADDR_W + 1;

    logic [AW1-1:0] base_x, size_x, end_x, addr_x;

    // Window bounds and match.
    always_comb begin
        addr_x = {1'b0, addr};
        base_x = AW1'({base16, 16'h0000});
        size_x = AW1'({({1'b0, size_m1} + 5'd1), 16'h0000});
        end_x  = base_x + size_x;
        hit    = enable && (base16 != 16'h0000) && (addr_x >= base_x) && (addr_x < end_x);
    end

endmodule

// File: rtl/legacy_region_decoder.sv
// Module: legacy region attribute decoder (top).
// Holds the control registers and routes each address to local DRAM, the
// external bus, or the management window. Routing is combinational from
// registered state; a register write shows on the outputs after its edge.
module legacy_region_decoder
    import lrd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_SHADOW = 7,
    localparam int NUM_SEG   = 2 * NUM_SHADOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_idx,
    input  logic [7:0]        cfg_wr_data,
    input  logic [7:0]        cfg_rd_idx,
    output logic [7:0]        cfg_rd_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_write,
    output logic              route_local,
    output logic              route_ext,
    output logic              route_smm
);

    logic [NUM_SEG-1:0][1:0] seg_attr;
    logic        vid_local, smm_en, smm_hit, vid_hit, seg_hit, want_local;
    logic [15:0] smm_base16;
    logic [3:0]  smm_size_m1;

    lrd_cfg_regs #(.NUM_SHADOW(NUM_SHADOW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
        .rd_idx(cfg_rd_idx), .rd_data(cfg_rd_data),
        .seg_attr(seg_attr), .vid_local(vid_local),
        .smm_en(smm_en), .smm_base16(smm_base16), .smm_size_m1(smm_size_m1)
    );

    lrd_legacy_decode #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) legacy_i (
        .addr(req_addr), .is_write(req_is_write), .seg_attr(seg_attr),
        .vid_local(vid_local), .vid_hit(vid_hit), .seg_hit(seg_hit),
        .want_local(want_local)
    );

    lrd_smm_window #(.ADDR_W(ADDR_W)) smm_i (
        .addr(req_addr), .enable(smm_en), .base16(smm_base16),
        .size_m1(smm_size_m1), .hit(smm_hit)
    );

    // Final priority: management hit, then the legacy decision.
    always_comb begin
        route_smm   = smm_hit;
        route_local = !smm_hit && want_local;
        route_ext   = !smm_hit && !want_local;
    end

    // R12: exactly one route.
    assert_one_route_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({route_local, route_ext, route_smm}) == 1);

    // R9: a management hit requires the enable and a nonzero base.
    assert_smm_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        route_smm |-> (smm_en && smm_base16 != 16'h0000));

    // R10: a window hit overrides the legacy decoders.
    assert_smm_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smm_hit |-> (route_smm && !route_local && !route_ext));

    // R7: enabled video window goes to DRAM when no window hit.
    assert_video_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_hit && vid_local && !smm_hit) |-> route_local);

    // R11: outside all decoded regions, DRAM is chosen unless the window hits.
    assert_default_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_hit && !seg_hit && !smm_hit) |-> route_local);

endmodule

// File: tb/legacy_region_decoder_tb_top.sv
// Bench: vector table walk plus directed reset, sweep and window tests.
module legacy_region_decoder_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr_en;
    logic [7:0]    cfg_wr_idx, cfg_wr_data, cfg_rd_idx, cfg_rd_data;
    logic [AW-1:0] req_addr;
    logic          req_is_write;
    logic          route_local, route_ext, route_smm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    legacy_region_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .req_addr(req_addr), .req_is_write(req_is_write),
        .route_local(route_local), .route_ext(route_ext), .route_smm(route_smm)
    );

    // Bench-side register mirror used by the reference model.
    logic [7:0] m_sh [7];
    logic [7:0] m_vid, m_ctl, m_lo, m_hi, m_sz;

    // Route codes: 0 local, 1 external, 2 management hit, 3 invalid.
    function automatic int got_route();
        int n = int'(route_local) + int'(route_ext) + int'(route_smm);
        if (n != 1) return 3;
        return route_smm ? 2 : (route_ext ? 1 : 0);
    endfunction

    function automatic int model_route(input logic [31:0] a, input logic w);
        logic [32:0] base, lim;
        logic [1:0]  at;
        int g;
        base = {1'b0, m_hi, m_lo, 16'h0};
        lim  = base + {12'h0, ({1'b0, m_sz[7:4]} + 5'd1), 16'h0};
        if (m_ctl[3] && {m_hi, m_lo} != 16'h0 && {1'b0, a} >= base && {1'b0, a} < lim)
            return 2;
        if (a >= 32'hA0000 && a <= 32'hBFFFF) return m_vid[1] ? 0 : 1;
        if (a >= 32'h80000 && a <= 32'h9FFFF)      at = m_sh[0][1:0];
        else if (a >= 32'hF0000 && a <= 32'hFFFFF) at = m_sh[0][5:4];
        else if (a >= 32'hC0000 && a <= 32'hEFFFF) begin
            g  = int'((a - 32'hC0000) >> 14);
            at = (g % 2 == 0) ? m_sh[1 + g/2][1:0] : m_sh[1 + g/2][5:4];
        end else return 0;
        return (w ? at[1] : at[0]) ? 0 : 1;
    endfunction

    task automatic check_route(input logic [31:0] a, input logic w, input int exp, input string tag);
        int got;
        req_addr = a; req_is_write = w;
        #1;
        got = got_route();
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0d got=%0d exp=%0d", tag, a, w, got, exp);
        end
    endtask

    task automatic check_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        cfg_rd_idx = idx;
        #1;
        n_tests++;
        if (cfg_rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s idx=%h got=%h exp=%h", tag, idx, cfg_rd_data, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = idx; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (idx)
            8'h57: m_ctl = d & 8'h08;
            8'h58: m_vid = d & 8'h02;
            8'hB8: m_lo  = d;
            8'hB9: m_hi  = d;
            8'hBB: m_sz  = d & 8'hF0;
            default: if (idx >= 8'h59 && idx <= 8'h5F) m_sh[idx - 8'h59] = d & 8'h33;
        endcase
    endtask

    // Vector table: {addr[39:8], requirement number[7:4], spare[3], write[2], expected route[1:0]}.
    // Valid after 0x58=0x02, 0x59=0x33, 0x5A=0x21, 0x5F=0x12, others zero.
    localparam int NV = 18;
    localparam logic [39:0] VEC [NV] = '{
        {32'h0007FFFF, 4'd11, 1'b0, 1'b0, 2'd0},  // R11 below decoded area
        {32'h00080000, 4'd4,  1'b0, 1'b0, 2'd0},  // R4 low area first byte
        {32'h0009FFFF, 4'd4,  1'b0, 1'b1, 2'd0},  // R4 low area last byte
        {32'h000A0000, 4'd7,  1'b0, 1'b0, 2'd0},  // R7 video on
        {32'h000BFFFF, 4'd7,  1'b0, 1'b1, 2'd0},  // R7 video last byte
        {32'h000C0000, 4'd6,  1'b0, 1'b0, 2'd0},  // R6 read enable only
        {32'h000C0000, 4'd6,  1'b0, 1'b1, 2'd1},  // R6 write to bus
        {32'h000C3FFF, 4'd5,  1'b0, 1'b0, 2'd0},  // R5 segment end
        {32'h000C4000, 4'd6,  1'b0, 1'b0, 2'd1},  // R6 high nibble read bus
        {32'h000C4000, 4'd6,  1'b0, 1'b1, 2'd0},  // R6 high nibble write DRAM
        {32'h000C8000, 4'd5,  1'b0, 1'b0, 2'd1},  // R5 next byte register zero
        {32'h000E8000, 4'd6,  1'b0, 1'b0, 2'd1},  // R6 last register low nibble
        {32'h000E8000, 4'd6,  1'b0, 1'b1, 2'd0},
        {32'h000EC000, 4'd6,  1'b0, 1'b0, 2'd0},
        {32'h000EFFFF, 4'd6,  1'b0, 1'b1, 2'd1},
        {32'h000F0000, 4'd4,  1'b0, 1'b0, 2'd0},  // R4 top area
        {32'h000FFFFF, 4'd4,  1'b0, 1'b1, 2'd0},
        {32'h00100000, 4'd11, 1'b0, 1'b1, 2'd0}   // R11 above 1 MB
    };

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_idx = 8'h00; cfg_wr_data = 8'h00;
        cfg_rd_idx = 8'h00; req_addr = '0; req_is_write = 1'b0;
        for (int i = 0; i < 7; i++) m_sh[i] = (i == 0) ? 8'h03 : 8'h00;
        m_vid = 8'h00; m_ctl = 8'h00; m_lo = 8'h0A; m_hi = 8'h00; m_sz = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset readback and reset routing.
        check_rd(8'h59, 8'h03, "R1");
        for (int i = 8'h5A; i <= 8'h5F; i++) check_rd(8'(i), 8'h00, "R1");
        check_rd(8'hB8, 8'h0A, "R1");
        check_rd(8'h57, 8'h00, "R1");
        check_rd(8'h58, 8'h00, "R1");
        check_rd(8'hB9, 8'h00, "R1");
        check_rd(8'hBB, 8'h00, "R1");
        check_route(32'h80000, 1'b1, 0, "R1");
        check_route(32'hF0000, 1'b0, 1, "R1");
        check_route(32'hA0000, 1'b0, 1, "R1");

        // R2: write timing; the route changes only after the sampling edge.
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = 8'h58; cfg_wr_data = 8'hFF;
        check_route(32'hA0000, 1'b0, 1, "R2");
        @(negedge clk);
        cfg_wr_en = 1'b0; m_vid = 8'h02;
        check_route(32'hA0000, 1'b0, 0, "R2");
        check_rd(8'h58, 8'h02, "R2");

        // R2: masking on the attribute registers.
        cfg_write(8'h59, 8'hFF);
        check_rd(8'h59, 8'h33, "R2");
        cfg_write(8'h5A, 8'h21);
        cfg_write(8'h5F, 8'h12);
        check_rd(8'h5F, 8'h12, "R2");

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            check_route(VEC[v][39:8], VEC[v][2], int'(VEC[v][1:0]),
                        $sformatf("R%0d", VEC[v][7:4]));
        end

        // R5/R6: every segment edge with every attribute code, both directions.
        cfg_write(8'h58, 8'h00);
        for (int s = 0; s < 14; s++) begin
            for (int at = 0; at < 4; at++) begin
                logic [7:0]  idx, val;
                logic [31:0] lo, hi;
                idx = 8'(8'h59 + s / 2);
                val = (s % 2 == 0) ? ((m_sh[s/2] & 8'hF0) | 8'(at))
                                   : ((m_sh[s/2] & 8'h0F) | 8'(at << 4));
                cfg_write(idx, val);
                lo = (s == 0) ? 32'h80000 : (s == 1) ? 32'hF0000 : 32'hC0000 + 32'(s - 2) * 32'h4000;
                hi = (s == 0) ? 32'h9FFFF : (s == 1) ? 32'hFFFFF : lo + 32'h3FFF;
                check_route(lo, 1'b0, (at & 1) ? 0 : 1, "R6");
                check_route(lo, 1'b1, (at & 2) ? 0 : 1, "R6");
                check_route(hi, 1'b0, model_route(hi, 1'b0), "R5");
                check_route(hi, 1'b1, model_route(hi, 1'b1), "R5");
            end
        end
        check_route(32'h7FFFF, 1'b1, 0, "R11");
        check_route(32'hA0000, 1'b1, 1, "R7");

        // R9/R10: enable with reset base 0x000A gives 0xA0000..0xAFFFF.
        cfg_write(8'h57, 8'hFF);
        check_rd(8'h57, 8'h08, "R2");
        check_route(32'hA0000, 1'b0, 2, "R10");
        check_route(32'hAFFFF, 1'b1, 2, "R10");
        check_route(32'hB0000, 1'b0, model_route(32'hB0000, 1'b0), "R8");

        // R8: base 0xC0000, size 2 x 64 KB.
        cfg_write(8'hB8, 8'h0C);
        cfg_write(8'hBB, 8'h1F);
        check_rd(8'hBB, 8'h10, "R2");
        check_route(32'hC0000, 1'b1, 2, "R8");
        check_route(32'hDFFFF, 1'b0, 2, "R8");
        check_route(32'hE0000, 1'b0, model_route(32'hE0000, 1'b0), "R8");
        check_route(32'hBFFFF, 1'b0, 1, "R8");

        // R9: zero base with enable set claims nothing.
        cfg_write(8'hB8, 8'h00);
        check_route(32'h00000000, 1'b0, 0, "R9");
        check_route(32'h0000FFFF, 1'b1, 0, "R9");

        // R8: window at the top of the address space.
        cfg_write(8'hB9, 8'hFF);
        cfg_write(8'hB8, 8'hFF);
        cfg_write(8'hBB, 8'hF0);
        check_route(32'hFFFFFFFF, 1'b0, 2, "R8");
        check_route(32'hFFFF0000, 1'b1, 2, "R8");
        check_route(32'hFFFEFFFF, 1'b0, 0, "R8");

        // R9: enable cleared.
        cfg_write(8'h57, 8'h00);
        check_route(32'hFFFFFFFF, 1'b0, 0, "R9");

        // R3: unused indices.
        cfg_write(8'h56, 8'hFF);
        cfg_write(8'hBA, 8'hFF);
        check_rd(8'h56, 8'h00, "R3");
        check_rd(8'hBA, 8'h00, "R3");
        check_rd(8'h60, 8'h00, "R3");
        check_rd(8'h57, 8'h00, "R3");
        check_rd(8'h58, 8'h00, "R3");
        check_route(32'hFFFFFFFF, 1'b0, 0, "R3");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule